// File: doc/BRIEF.md
# SPI Command Decoder for a Touch-Screen Converter Controller

This block is the serial front end of a touch-screen converter controller. A host acting as SPI master clocks command bytes into it in mode 0: the clock idles low, bits are captured on the rising edge, and bits change on the falling edge. While each bit shifts in, the block shifts a bit back out on MISO. The block runs entirely in the system clock domain. SCLK, CS_n and MOSI pass through two-flop synchronisers, and SCLK edges are detected after synchronisation. Because of this, SCLK must stay at each level for at least four system clocks.

Bit 7 of every command byte decides its type. A byte with bit 7 set is a conversion byte. It selects a converter function, a resolution and a software reset, and it can stop conversion. A byte with bit 7 clear is a register-access byte. It addresses one of sixteen 16-bit registers that sit outside the block, and a 16-bit data phase follows it.

Chip select may stay low across any number of commands. Byte and word framing therefore comes from a bit counter, and a rising CS_n only abandons any part-finished unit. During a command byte or a write data phase, MISO returns the most recent command byte followed by zeros. During a read data phase, MISO returns the addressed register.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After reset, `spi_miso`, `conv_func`, `conv_res12`, `reg_addr`, `reg_pend`, `reg_wdata` and every pulse output are 0.
- R2: Bits are taken from MOSI on SCLK rising edges, MSB first, and MISO changes only after falling edges. The first MISO bit is valid before the first rising edge after CS_n falls, and MISO is 0 while CS_n is high.
- R3: With CS_n held low, consecutive 8-bit command units are framed by a counter alone, and each is decoded in turn.
- R4: A command byte with bit 7 = 1 loads `conv_func` from bits 6:3 and `conv_res12` from bit 2 (1 = 12-bit, 0 = 10-bit). It also pulses `conv_start` for one clock.
- R5: When bit 0 of a conversion byte is 1, `conv_stop` pulses and `conv_start` does not pulse for that byte. The two pulses are never high together.
- R6: When bit 1 of a conversion byte is 1, `bank_rst` pulses for one clock.
- R7: A command byte with bit 7 = 0 and bit 0 = 0 is a register access. It loads `reg_addr` from bits 6:3 and `reg_pend` from bit 2, and bit 1 selects a read (1) or a write (0). A 16-bit data phase follows.
- R8: In a write access, the 16 data bits (MSB first) appear on `reg_wdata`, and `reg_wr_en` pulses once, after the 16th rising edge.
- R9: In a read access, MISO shifts out `reg_rdata` for the addressed register, MSB first, during the data phase, and no write pulse occurs.
- R10: An access byte with reserved bit 0 = 1 is ignored. `reg_addr` keeps its value, no data phase follows, and the next byte is a command.
- R11: A CS_n rising edge abandons a partial byte or data phase. No write or conversion pulse results, and the next byte after reselect is a command.
- R12: During a command byte and during a write data phase, MISO carries the last complete command byte received (0 after reset) followed by zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| conv_func | output | 4 | Latched converter function code |
| conv_start | output | 1 | One-clock pulse to start a conversion |
| conv_res12 | output | 1 | Latched resolution, 1 = 12-bit |
| conv_stop | output | 1 | One-clock pulse to stop all conversion |
| bank_rst | output | 1 | One-clock pulse to restore register defaults |
| reg_addr | output | 4 | Register address of the last access |
| reg_pend | output | 1 | Pending-control flag of the last access |
| reg_wr_en | output | 1 | One-clock write strobe |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data for `reg_addr` |

## Verification
Conversion bytes are sent with different function codes and resolutions, both with the stop bit and without it. This separates a correct start/stop priority from a decoder that always starts. Several commands share one select, which shows that framing survives without CS edges. The echoed MISO byte reveals how the previous unit was framed. A write followed by a read-back under the same select tells a correct 16-bit data phase from a short or misaligned one. A byte with the reserved bit set, followed at once by a command, shows that no data phase was entered. Selects dropped after 4 and after 8 data bits show that part-finished units leave no trace.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int CMD_W  = 8;
    localparam int FLD_W  = 4;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic             is_conv;
        logic [FLD_W-1:0] func;
        logic             res12;
        logic             swrst;
        logic             stop;
        logic [FLD_W-1:0] addr;
        logic             pend;
        logic             rd;
        logic             rsv_bad;
    } cmd_fields_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;
    logic [STAGES-1:0][WIDTH-1:0] stg_d;

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_edge.sv
module spi_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;
    logic prev_d;

    always_comb prev_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/spi_cmd_fields.sv
module spi_cmd_fields
    import spi_cmd_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    output cmd_fields_t      fld_o
);
    always_comb begin
        fld_o.is_conv = cmd_i[7];
        fld_o.func    = cmd_i[6:3];
        fld_o.res12   = cmd_i[2];
        fld_o.swrst   = cmd_i[1];
        fld_o.stop    = cmd_i[0];
        fld_o.addr    = cmd_i[6:3];
        fld_o.pend    = cmd_i[2];
        fld_o.rd      = cmd_i[1];
        fld_o.rsv_bad = cmd_i[0];
    end
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
    import spi_cmd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [FLD_W-1:0]  conv_func,
    output logic              conv_start,
    output logic              conv_res12,
    output logic              conv_stop,
    output logic              bank_rst,
    output logic [FLD_W-1:0]  reg_addr,
    output logic              reg_pend,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int PAD_W = DATA_W - CMD_W;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-2:0]  rx;
        logic [DATA_W-1:0]  tx;
        logic               load_pend;
        logic               load_rd;
        logic [CMD_W-1:0]   echo;
        logic [FLD_W-1:0]   func;
        logic               res12;
        logic               start;
        logic               stop;
        logic               brst;
        logic [FLD_W-1:0]   addr;
        logic               pend;
        logic               rd;
        logic               wr;
        logic [DATA_W-1:0]  wdata;
    } state_t;

    state_t q, d;

    logic [2:0]       sync_out;
    logic             csn_s, sclk_s, mosi_s;
    logic             cs_act, sclk_rise, sclk_fall;
    logic [CMD_W-1:0] cmd_byte;
    cmd_fields_t      fld;

    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({spi_cs_n, spi_sclk, spi_mosi}),
        .sync_o (sync_out)
    );

    assign {csn_s, sclk_s, mosi_s} = sync_out;
    assign cs_act = ~csn_s;

    spi_edge #(.RST_VAL(1'b0)) u_sclk_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(sclk_s),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    assign cmd_byte = {q.rx[CMD_W-2:0], mosi_s};

    spi_cmd_fields u_fields (
        .cmd_i(cmd_byte),
        .fld_o(fld)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.stop  = 1'b0;
        d.brst  = 1'b0;
        d.wr    = 1'b0;
        if (!cs_act) begin
            d.phase     = PH_CMD;
            d.cnt       = '0;
            d.load_pend = 1'b0;
            d.load_rd   = 1'b0;
            d.tx        = {q.echo, {PAD_W{1'b0}}};
        end else if (sclk_rise) begin
            d.rx  = {q.rx[DATA_W-3:0], mosi_s};
            d.cnt = q.cnt + 1'b1;
            if (q.phase == PH_CMD && q.cnt == CNT_W'(CMD_W-1)) begin
                d.cnt       = '0;
                d.echo      = cmd_byte;
                d.load_pend = 1'b1;
                d.load_rd   = 1'b0;
                if (fld.is_conv) begin
                    d.func  = fld.func;
                    d.res12 = fld.res12;
                    d.stop  = fld.stop;
                    d.start = ~fld.stop;
                    d.brst  = fld.swrst;
                end else if (!fld.rsv_bad) begin
                    d.addr    = fld.addr;
                    d.pend    = fld.pend;
                    d.rd      = fld.rd;
                    d.load_rd = fld.rd;
                    d.phase   = PH_DATA;
                end
            end else if (q.phase == PH_DATA && q.cnt == CNT_W'(DATA_W-1)) begin
                d.cnt       = '0;
                d.phase     = PH_CMD;
                d.load_pend = 1'b1;
                d.load_rd   = 1'b0;
                if (!q.rd) begin
                    d.wr    = 1'b1;
                    d.wdata = {q.rx, mosi_s};
                end
            end
        end else if (sclk_fall) begin
            if (q.load_pend) begin
                d.load_pend = 1'b0;
                d.tx = q.load_rd ? reg_rdata : {q.echo, {PAD_W{1'b0}}};
            end else begin
                d.tx = {q.tx[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign spi_miso   = cs_act & q.tx[DATA_W-1];
    assign conv_func  = q.func;
    assign conv_res12 = q.res12;
    assign conv_start = q.start;
    assign conv_stop  = q.stop;
    assign bank_rst   = q.brst;
    assign reg_addr   = q.addr;
    assign reg_pend   = q.pend;
    assign reg_wr_en  = q.wr;
    assign reg_wdata  = q.wdata;

    // R5
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_start && conv_stop));

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R8
    wr_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(q.phase == PH_DATA));

    // R3
    cmd_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_CMD) |-> (q.cnt < CNT_W'(CMD_W)));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_CMD && $past(q.phase == PH_CMD)) |-> $stable(reg_addr));

    // R11
    deselect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (q.phase == PH_CMD && !reg_wr_en && !conv_start && !conv_stop));
endmodule

// File: tb/sim_spi_cmd_decoder.sv
module sim_spi_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [3:0]  conv_func;
    logic        conv_start, conv_res12, conv_stop, bank_rst;
    logic [3:0]  reg_addr;
    logic        reg_pend, reg_wr_en;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;

    logic [15:0] bank [16];
    int n_chk = 0, n_fail = 0;
    int n_start = 0, n_stop = 0, n_brst = 0, n_wr = 0;
    int e_start = 0, e_stop = 0, e_brst = 0, e_wr = 0;
    logic [15:0] got;

    always #5 clk = ~clk;

    spi_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .conv_func(conv_func),
        .conv_start(conv_start), .conv_res12(conv_res12), .conv_stop(conv_stop),
        .bank_rst(bank_rst), .reg_addr(reg_addr), .reg_pend(reg_pend),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = bank[reg_addr];

    initial begin
        for (int i = 0; i < 16; i++) bank[i] = 16'hA500 + 16'(i);
    end

    always @(posedge clk) begin
        if (bank_rst) begin
            for (int i = 0; i < 16; i++) bank[i] <= 16'hA500 + 16'(i);
        end else if (reg_wr_en) begin
            bank[reg_addr] <= reg_wdata;
        end
    end

    always @(negedge clk) begin
        if (conv_start) n_start++;
        if (conv_stop)  n_stop++;
        if (bank_rst)   n_brst++;
        if (reg_wr_en)  n_wr++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    task automatic xfer(input logic [15:0] dout, input int nbits, output logic [15:0] din);
        din = '0;
        for (int i = nbits - 1; i >= 0; i--) begin
            spi_mosi = dout[i];
            repeat (8) @(negedge clk);
            din[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (8) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic sel();
        spi_cs_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic desel();
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic counts(input string req);
        chk({req, " start count"}, n_start, e_start);
        chk({req, " stop count"},  n_stop,  e_stop);
        chk({req, " bankrst count"}, n_brst, e_brst);
        chk({req, " write count"}, n_wr,    e_wr);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (10) @(negedge clk);
        // R1 reset state
        chk("R1 miso", spi_miso, 0);
        chk("R1 func", conv_func, 0);
        chk("R1 res12", conv_res12, 0);
        chk("R1 addr", reg_addr, 0);
        chk("R1 pend", reg_pend, 0);
        chk("R1 wdata", reg_wdata, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        counts("R1");

        // R4 conversion byte 1_0101_1_0_0, R2/R12 echo 0 after reset
        sel();
        xfer(16'h00AC, 8, got);
        chk("R12 echo after reset", got[7:0], 8'h00);
        e_start++;
        chk("R4 func", conv_func, 4'h5);
        chk("R4 res12", conv_res12, 1'b1);
        counts("R4");

        // R3 second command same select; R5 stop priority
        xfer(16'h0099, 8, got);
        chk("R3 echo framing", got[7:0], 8'hAC);
        e_stop++;
        chk("R5 func", conv_func, 4'h3);
        chk("R5 res12", conv_res12, 1'b0);
        counts("R5");
        desel();
        chk("R2 miso low when deselected", spi_miso, 1'b0);

        // R6 software reset with start
        sel();
        chk("R2 first bit before edge", spi_miso, 1'b1);
        xfer(16'h0082, 8, got);
        chk("R2 echo", got[7:0], 8'h99);
        e_start++;
        e_brst++;
        counts("R6");
        desel();

        // R7 R8 write to addr 3, pend 1
        sel();
        xfer(16'h001C, 8, got);
        chk("R12 echo", got[7:0], 8'h82);
        chk("R7 addr", reg_addr, 4'h3);
        chk("R7 pend", reg_pend, 1'b1);
        xfer(16'hBEEF, 16, got);
        chk("R12 write phase echo", got, 16'h1C00);
        e_wr++;
        chk("R8 wdata", reg_wdata, 16'hBEEF);
        counts("R8");
        // R9 read back same select
        xfer(16'h001A, 8, got);
        chk("R3 echo after data phase", got[7:0], 8'h1C);
        chk("R7 pend clear", reg_pend, 1'b0);
        xfer(16'h0000, 16, got);
        chk("R9 read data", got, 16'hBEEF);
        counts("R9");
        desel();

        // R9 read default of addr 7
        sel();
        xfer(16'h003A, 8, got);
        chk("R12 echo", got[7:0], 8'h1A);
        xfer(16'hFFFF, 16, got);
        chk("R9 read default", got, 16'hA507);
        counts("R9 read");
        desel();

        // R10 reserved bit set: ignored, next byte is command
        sel();
        xfer(16'h002D, 8, got);
        chk("R10 echo in", got[7:0], 8'h3A);
        chk("R10 addr held", reg_addr, 4'h7);
        xfer(16'h00AC, 8, got);
        chk("R10 no data phase", got[7:0], 8'h2D);
        e_start++;
        counts("R10");
        desel();
        sel();
        xfer(16'h002A, 8, got);
        chk("R10 echo", got[7:0], 8'hAC);
        xfer(16'h0000, 16, got);
        chk("R10 addr5 untouched", got, 16'hA505);
        desel();

        // R11 abort write after 8 data bits
        sel();
        xfer(16'h000C, 8, got);
        xfer(16'h0055, 8, got);
        desel();
        counts("R11 aborted write");
        // R11 abort partial command
        sel();
        xfer(16'h000F, 4, got);
        desel();
        counts("R11 aborted byte");
        sel();
        xfer(16'h0099, 8, got);
        chk("R11 echo after abort", got[7:0], 8'h0C);
        e_stop++;
        counts("R11 command after abort");
        xfer(16'h000A, 8, got);
        xfer(16'h0000, 16, got);
        chk("R11 addr1 untouched", got, 16'hA501);
        desel();
        counts("R11 final");

        report();
    end
endmodule